// File: doc/BRIEF.md
# Serial In-System Programming Command Engine

This block is the target side of a four-byte serial programming link. A host holds the target's programming-reset input low and clocks 32-bit commands into the block over an SPI mode-0 link. SCK, MOSI and MISO are oversampled by the system clock. The block decodes the first byte of each frame into one of these operations:

- unlocking programming
- erasing the whole memory
- polling the busy flag
- setting the extended flash address
- loading the flash and EEPROM page buffers
- committing a page
- writing a single EEPROM byte or the configuration byte
- reading any of these stores back

The nonvolatile stores are modelled as register arrays. Flash is word-organised, with a low and a high byte per word, and is written a page at a time through a byte-wide buffer. The EEPROM can be written one byte at a time or one four-byte page at a time. A write or erase that is accepted holds a busy flag for a minimum time. That time is built from a cycles-per-100-microsecond parameter: 4.5 ms for flash, 4.0 ms for EEPROM, 9.0 ms for an erase and 4.5 ms for the configuration byte.

During each byte of a frame, MISO returns the byte received one byte earlier. In the last byte, a read or poll command replaces that echo with the requested data.

Top module: `isp_cmd_engine`

## Requirements
- R1: Frames are 32 bits, sent MSB first. MOSI is sampled on the rising SCK edge and MISO changes on the falling edge. A command takes effect after its 32nd bit. During frame bytes 2, 3 and 4, MISO returns the byte received just before, unless R5 or R10 selects other data for byte 4.
- R2: The frame bit counter returns to zero while the programming reset input is high. It also returns to zero when no SCK edge arrives for IDLE_CYC clocks in the middle of a frame, so the next frame starts aligned.
- R3: Frame 0xAC 0x53 xx xx unlocks programming. Until that frame arrives, every other command is ignored and byte 4 carries only the echo. Raising the programming reset input locks the block again.
- R4: Frame 0xAC 0x80 xx xx sets every flash and EEPROM byte to 0xFF and empties both page buffers. It does not change the configuration byte.
- R5: Frame 0xF0 xx xx xx returns {7'b0, busy} in byte 4.
- R6: Frame 0x4D xx E xx stores E. The flash word address is formed as {E[EXT_BITS-1:0], byte2[MSB_BITS-1:0], byte3[LSB_BITS-1:0]}. With the defaults that is {E[0], byte2[0], byte3[4:0]}, and the page slot is byte3[2:0].
- R7: Frame 0x40 A B D loads D into the low-byte buffer slot of the addressed word; opcode 0x48 does the same for the high byte. Frame 0x4C A B xx writes only the buffer slots loaded since the last commit into the page that contains the addressed word, then empties the buffer.
- R8: Frame 0xC1 xx B D loads D into EEPROM buffer slot B[1:0]. Frame 0xC2 xx B xx writes the loaded slots into the bytes {B[7:2], slot}. Bytes on that page that were not loaded keep their old value.
- R9: Frame 0xC0 xx B D replaces the whole of EEPROM byte B with D. The old value has no influence on the result.
- R10: Byte 4 of a read frame returns the stored value. Opcode 0x20 reads the flash low byte and 0x28 the flash high byte, both at the R6 address. Opcode 0xA0 reads EEPROM byte byte3. Opcode 0x50 reads the configuration byte.
- R11: After a write or erase is accepted, busy stays set for wait_cycles(t) = t × CYC_PER_100US clocks. t is 45 for a flash page, 40 for an EEPROM write, 90 for an erase and 45 for the configuration byte.
- R12: A write, commit, erase or configuration write that ends while busy is set is discarded. Buffer loads are still accepted while busy is set.
- R13: Frame 0xAC 0xA0 xx D stores D as the configuration byte. Its reset value is FUSE_INIT (0xE1 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| isp_rst_n | input | 1 | Target programming reset; the link is active while it is low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The hardest behaviour to reach from the pins is the busy window of each operation class, because the flag is seen only through a poll frame whose reply is captured partway through that frame. The bench therefore starts a poll after a fixed delay chosen so that the capture point lands between the EEPROM and flash windows, and just before and after the erase window. This separates the classes with tens of cycles of margin. Discarding a write while busy is reached by sending a second write directly after the first. Partial page commits are reached by loading only some slots over bytes that already hold known data.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_SYS     = 8'hAC;
  localparam logic [7:0] SUB_UNLOCK = 8'h53;
  localparam logic [7:0] SUB_ERASE  = 8'h80;
  localparam logic [7:0] SUB_CFG_WR = 8'hA0;
  localparam logic [7:0] OP_POLL    = 8'hF0;
  localparam logic [7:0] OP_EXT     = 8'h4D;
  localparam logic [7:0] OP_FL_LDL  = 8'h40;
  localparam logic [7:0] OP_FL_LDH  = 8'h48;
  localparam logic [7:0] OP_FL_PG   = 8'h4C;
  localparam logic [7:0] OP_FL_RDL  = 8'h20;
  localparam logic [7:0] OP_FL_RDH  = 8'h28;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_EE_LD   = 8'hC1;
  localparam logic [7:0] OP_EE_PG   = 8'hC2;
  localparam logic [7:0] OP_CFG_RD  = 8'h50;

  // minimum hold times in units of 100 us
  localparam int unsigned T_FLASH = 45;
  localparam int unsigned T_EE    = 40;
  localparam int unsigned T_ERASE = 90;
  localparam int unsigned T_CFG   = 45;

  typedef struct packed {
    logic erase;
    logic cfg_wr;
    logic fl_ld;
    logic fl_hi;
    logic fl_pg;
    logic ee_wr;
    logic ee_ld;
    logic ee_pg;
  } nvm_op_t;

  function automatic int unsigned wait_cycles(input int unsigned tenths,
                                              input int unsigned per100us);
    return tenths * per100us;
  endfunction
endpackage

// File: rtl/isp_spi_rx.sv
module isp_spi_rx #(
  parameter int unsigned IDLE_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        isp_rst_n,
  input  logic        sck,
  input  logic        mosi,
  input  logic [7:0]  reply_i,
  output logic        miso,
  output logic        hdr_done_o,
  output logic [23:0] hdr_o,
  output logic        frame_done_o,
  output logic [31:0] frame_o
);
  localparam int unsigned IW = $clog2(IDLE_CYC + 1);

  logic          sck_q, sck_qq, mosi_q;
  logic [4:0]    bit_cnt;
  logic [31:0]   sr;
  logic [7:0]    tx_sr;
  logic          miso_q;
  logic [IW-1:0] idle_cnt;

  wire        sck_rise = sck_q & ~sck_qq;
  wire        sck_fall = ~sck_q & sck_qq;
  wire [31:0] next_sr  = {sr[30:0], mosi_q};
  wire        byte_end = sck_rise && (bit_cnt[2:0] == 3'd7);
  wire        idle_hit = (bit_cnt != 5'd0) && (idle_cnt == IW'(IDLE_CYC - 1));

  assign hdr_done_o   = sck_rise && (bit_cnt == 5'd23);
  assign frame_done_o = sck_rise && (bit_cnt == 5'd31);
  assign hdr_o        = next_sr[23:0];
  assign frame_o      = next_sr;
  assign miso         = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; sck_qq <= 1'b0; mosi_q <= 1'b0;
      bit_cnt <= '0; sr <= '0; tx_sr <= '0; miso_q <= 1'b0; idle_cnt <= '0;
    end else begin
      sck_q  <= sck;
      sck_qq <= sck_q;
      mosi_q <= mosi;
      if (isp_rst_n) begin
        bit_cnt <= '0; tx_sr <= '0; miso_q <= 1'b0; idle_cnt <= '0;
      end else if (sck_rise) begin
        sr       <= next_sr;
        bit_cnt  <= bit_cnt + 5'd1;
        idle_cnt <= '0;
        if (byte_end) begin
          if (bit_cnt == 5'd23)      tx_sr <= reply_i;
          else if (bit_cnt == 5'd31) tx_sr <= 8'h00;
          else                       tx_sr <= next_sr[7:0];
        end
      end else if (sck_fall) begin
        miso_q   <= tx_sr[7];
        tx_sr    <= {tx_sr[6:0], 1'b0};
        idle_cnt <= '0;
      end else if (idle_hit) begin
        bit_cnt <= '0; idle_cnt <= '0; tx_sr <= '0; miso_q <= 1'b0;
      end else if (bit_cnt != 5'd0) begin
        idle_cnt <= idle_cnt + IW'(1);
      end
    end
  end

  // R2
  r2_rst_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isp_rst_n) |=> (bit_cnt == 5'd0));
  // R1
  r1_frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (bit_cnt == 5'd0));
endmodule

// File: rtl/isp_busy_timer.sv
module isp_busy_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start_i)        cnt <= len_i;
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);

  // R11
  r11_busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R11
  r11_busy_full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt) == CW'(1)));
  // R12
  r12_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/isp_nvm.sv
module isp_nvm
  import isp_pkg::*;
#(
  parameter int unsigned  FLASH_AW   = 7,
  parameter int unsigned  FPAGE_BITS = 3,
  parameter logic [7:0]   CFG_INIT   = 8'hE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  nvm_op_t             op_i,
  input  logic [FLASH_AW-1:0] faddr_i,
  input  logic [7:0]          eaddr_i,
  input  logic [7:0]          data_i,
  input  logic [FLASH_AW-1:0] rd_faddr_i,
  input  logic [7:0]          rd_eaddr_i,
  output logic [7:0]          rd_flo_o,
  output logic [7:0]          rd_fhi_o,
  output logic [7:0]          rd_ee_o,
  output logic [7:0]          cfg_o
);
  localparam int unsigned FWORDS = 1 << FLASH_AW;
  localparam int unsigned FPAGE  = 1 << FPAGE_BITS;
  localparam int unsigned EBYTES = 256;
  localparam int unsigned EPB    = 2;
  localparam int unsigned EPAGE  = 1 << EPB;

  logic [7:0]       fl_lo [FWORDS];
  logic [7:0]       fl_hi [FWORDS];
  logic [7:0]       ee    [EBYTES];
  logic [7:0]       fb_lo [FPAGE];
  logic [7:0]       fb_hi [FPAGE];
  logic [FPAGE-1:0] fm_lo, fm_hi;
  logic [7:0]       eb    [EPAGE];
  logic [EPAGE-1:0] em;
  logic [7:0]       cfg;

  wire [FPAGE_BITS-1:0] fslot = faddr_i[FPAGE_BITS-1:0];
  wire [EPB-1:0]        eslot = eaddr_i[EPB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FWORDS; i++) begin fl_lo[i] <= 8'hFF; fl_hi[i] <= 8'hFF; end
      for (int i = 0; i < EBYTES; i++) ee[i] <= 8'hFF;
      for (int i = 0; i < FPAGE; i++) begin fb_lo[i] <= 8'h00; fb_hi[i] <= 8'h00; end
      for (int i = 0; i < EPAGE; i++) eb[i] <= 8'h00;
      fm_lo <= '0; fm_hi <= '0; em <= '0; cfg <= CFG_INIT;
    end else if (op_i.erase) begin
      for (int i = 0; i < FWORDS; i++) begin fl_lo[i] <= 8'hFF; fl_hi[i] <= 8'hFF; end
      for (int i = 0; i < EBYTES; i++) ee[i] <= 8'hFF;
      fm_lo <= '0; fm_hi <= '0; em <= '0;
    end else begin
      if (op_i.cfg_wr) cfg <= data_i;
      if (op_i.fl_ld) begin
        if (op_i.fl_hi) begin fb_hi[fslot] <= data_i; fm_hi[fslot] <= 1'b1; end
        else            begin fb_lo[fslot] <= data_i; fm_lo[fslot] <= 1'b1; end
      end
      if (op_i.fl_pg) begin
        for (int i = 0; i < FPAGE; i++) begin
          if (fm_lo[i]) fl_lo[{faddr_i[FLASH_AW-1:FPAGE_BITS], FPAGE_BITS'(i)}] <= fb_lo[i];
          if (fm_hi[i]) fl_hi[{faddr_i[FLASH_AW-1:FPAGE_BITS], FPAGE_BITS'(i)}] <= fb_hi[i];
        end
        fm_lo <= '0; fm_hi <= '0;
      end
      if (op_i.ee_wr) ee[eaddr_i] <= data_i;
      if (op_i.ee_ld) begin eb[eslot] <= data_i; em[eslot] <= 1'b1; end
      if (op_i.ee_pg) begin
        for (int i = 0; i < EPAGE; i++)
          if (em[i]) ee[{eaddr_i[7:EPB], EPB'(i)}] <= eb[i];
        em <= '0;
      end
    end
  end

  assign rd_flo_o = fl_lo[rd_faddr_i];
  assign rd_fhi_o = fl_hi[rd_faddr_i];
  assign rd_ee_o  = ee[rd_eaddr_i];
  assign cfg_o    = cfg;

  // R4
  r4_single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_i.erase, op_i.cfg_wr, op_i.fl_ld, op_i.fl_pg, op_i.ee_wr, op_i.ee_ld, op_i.ee_pg}));
  // R8
  r8_buffer_emptied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.ee_pg || op_i.erase) |=> (em == '0));
endmodule

// File: rtl/isp_cmd_engine.sv
module isp_cmd_engine
  import isp_pkg::*;
#(
  parameter int unsigned CYC_PER_100US = 20,
  parameter int unsigned IDLE_CYC      = 64,
  parameter int unsigned EXT_BITS      = 1,
  parameter int unsigned MSB_BITS      = 1,
  parameter int unsigned LSB_BITS      = 5,
  parameter int unsigned FPAGE_BITS    = 3,
  parameter logic [7:0]  FUSE_INIT     = 8'hE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic isp_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int unsigned FLASH_AW = EXT_BITS + MSB_BITS + LSB_BITS;
  localparam int unsigned W_FL = wait_cycles(T_FLASH, CYC_PER_100US);
  localparam int unsigned W_EE = wait_cycles(T_EE,    CYC_PER_100US);
  localparam int unsigned W_ER = wait_cycles(T_ERASE, CYC_PER_100US);
  localparam int unsigned W_CF = wait_cycles(T_CFG,   CYC_PER_100US);
  localparam int unsigned CW   = $clog2(W_ER + 1);

  function automatic logic [FLASH_AW-1:0] make_faddr(input logic [7:0] ext,
                                                     input logic [7:0] hi,
                                                     input logic [7:0] lo);
    return {ext[EXT_BITS-1:0], hi[MSB_BITS-1:0], lo[LSB_BITS-1:0]};
  endfunction

  logic        hdr_done, frame_done;
  logic [23:0] hdr;
  logic [31:0] frame;
  logic [7:0]  reply;
  logic        prog_en, busy;
  logic [7:0]  ext_q;
  nvm_op_t     op;
  logic        tmr_start;
  logic [CW-1:0] tmr_len;
  logic [7:0]  rd_flo, rd_fhi, rd_ee, cfg;

  wire [7:0] f1 = frame[31:24];
  wire [7:0] f2 = frame[23:16];
  wire [7:0] f3 = frame[15:8];
  wire [7:0] f4 = frame[7:0];
  wire [7:0] h1 = hdr[23:16];
  wire [7:0] h2 = hdr[15:8];
  wire [7:0] h3 = hdr[7:0];
  wire       unlock_frame = frame_done && (f1 == OP_SYS) && (f2 == SUB_UNLOCK);

  isp_spi_rx #(.IDLE_CYC(IDLE_CYC)) u_rx (
    .clk, .rst_n, .isp_rst_n, .sck, .mosi,
    .reply_i(reply), .miso,
    .hdr_done_o(hdr_done), .hdr_o(hdr),
    .frame_done_o(frame_done), .frame_o(frame)
  );

  // command decode at the end of the 32nd bit
  always_comb begin
    op        = '0;
    tmr_start = 1'b0;
    tmr_len   = '0;
    if (frame_done && prog_en) begin
      case (f1)
        OP_SYS: begin
          if (f2 == SUB_ERASE && !busy) begin
            op.erase = 1'b1; tmr_start = 1'b1; tmr_len = CW'(W_ER);
          end else if (f2 == SUB_CFG_WR && !busy) begin
            op.cfg_wr = 1'b1; tmr_start = 1'b1; tmr_len = CW'(W_CF);
          end
        end
        OP_FL_LDL: op.fl_ld = 1'b1;
        OP_FL_LDH: begin op.fl_ld = 1'b1; op.fl_hi = 1'b1; end
        OP_FL_PG: if (!busy) begin
          op.fl_pg = 1'b1; tmr_start = 1'b1; tmr_len = CW'(W_FL);
        end
        OP_EE_WR: if (!busy) begin
          op.ee_wr = 1'b1; tmr_start = 1'b1; tmr_len = CW'(W_EE);
        end
        OP_EE_LD: op.ee_ld = 1'b1;
        OP_EE_PG: if (!busy) begin
          op.ee_pg = 1'b1; tmr_start = 1'b1; tmr_len = CW'(W_EE);
        end
        default: ;
      endcase
    end
  end

  // reply chosen when byte 3 completes
  always_comb begin
    reply = h3;
    if (prog_en) begin
      case (h1)
        OP_POLL:   reply = {7'b0, busy};
        OP_FL_RDL: reply = rd_flo;
        OP_FL_RDH: reply = rd_fhi;
        OP_EE_RD:  reply = rd_ee;
        OP_CFG_RD: reply = cfg;
        default:   reply = h3;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_en <= 1'b0;
      ext_q   <= 8'h00;
    end else if (isp_rst_n) begin
      prog_en <= 1'b0;
    end else begin
      if (unlock_frame) prog_en <= 1'b1;
      if (frame_done && prog_en && f1 == OP_EXT) ext_q <= f3;
    end
  end

  isp_busy_timer #(.CW(CW)) u_tmr (
    .clk, .rst_n, .start_i(tmr_start), .len_i(tmr_len), .busy_o(busy)
  );

  isp_nvm #(.FLASH_AW(FLASH_AW), .FPAGE_BITS(FPAGE_BITS), .CFG_INIT(FUSE_INIT)) u_nvm (
    .clk, .rst_n, .op_i(op),
    .faddr_i(make_faddr(ext_q, f2, f3)), .eaddr_i(f3), .data_i(f4),
    .rd_faddr_i(make_faddr(ext_q, h2, h3)), .rd_eaddr_i(h3),
    .rd_flo_o(rd_flo), .rd_fhi_o(rd_fhi), .rd_ee_o(rd_ee), .cfg_o(cfg)
  );

  // R3
  r3_busy_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> prog_en);
  // R3
  r3_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isp_rst_n) |=> !prog_en);
  // R5
  r5_poll_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && prog_en && h1 == OP_POLL) |-> (reply[7:1] == 7'b0));
endmodule

// File: tb/tb_isp_cmd_engine.sv
module tb_isp_cmd_engine;
  localparam int CYC = 20;
  localparam int IDLE = 64;
  localparam int HALF = 4;
  localparam int W_FL = 45 * CYC;
  localparam int W_EE = 40 * CYC;
  localparam int W_ER = 90 * CYC;
  localparam int W_CF = 45 * CYC;

  logic clk = 1'b0, rst_n = 1'b0, isp_rst_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  wire  miso;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] r3, r4;

  always #2 clk = ~clk;

  isp_cmd_engine #(.CYC_PER_100US(CYC), .IDLE_CYC(IDLE)) dut (
    .clk, .rst_n, .isp_rst_n, .sck, .mosi, .miso
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input logic [7:0] d);
    logic [31:0] tx, rx;
    tx = {a, b, c, d};
    rx = '0;
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk); mosi = tx[i];
      clks(HALF);
      rx[i] = miso;
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
    end
    clks(12);
    r3 = rx[15:8];
    r4 = rx[7:0];
  endtask

  task automatic t_locked;
    chk("R1 reset miso", {7'b0, miso}, 8'h00);
    isp_rst_n = 1'b0; clks(4);
    xfer(8'hC0, 8'h00, 8'h10, 8'h33);
    chk("R1 echo byte3", r3, 8'h00);
    xfer(8'hA0, 8'h00, 8'h10, 8'h00);
    chk("R3 locked read echo", r4, 8'h10);
    xfer(8'hAC, 8'h53, 8'h00, 8'h00);
    chk("R1 unlock echo", r3, 8'h53);
    xfer(8'hA0, 8'h00, 8'h10, 8'h00);
    chk("R3 locked write ignored", r4, 8'hFF);
  endtask

  task automatic t_ee_byte;
    xfer(8'hC0, 8'h00, 8'h10, 8'hF0);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00);
    chk("R5 poll busy", r4, 8'h01);
    clks(W_EE);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00);
    chk("R5 poll idle", r4, 8'h00);
    xfer(8'hC0, 8'h00, 8'h10, 8'h0F);
    clks(W_EE);
    xfer(8'hA0, 8'h00, 8'h10, 8'h00);
    chk("R9 byte replaced", r4, 8'h0F);
  endtask

  task automatic t_discard;
    xfer(8'hC0, 8'h00, 8'h20, 8'h11);
    xfer(8'hC0, 8'h00, 8'h21, 8'h22);
    clks(W_EE);
    xfer(8'hA0, 8'h00, 8'h20, 8'h00);
    chk("R12 first write kept", r4, 8'h11);
    xfer(8'hA0, 8'h00, 8'h21, 8'h00);
    chk("R12 busy write dropped", r4, 8'hFF);
  endtask

  task automatic t_ee_page;
    xfer(8'hC0, 8'h00, 8'h40, 8'hAA);
    xfer(8'hC1, 8'h00, 8'h01, 8'h55);
    xfer(8'hC1, 8'h00, 8'h03, 8'h66);
    clks(W_EE);
    xfer(8'hC2, 8'h00, 8'h40, 8'h00);
    clks(W_EE);
    xfer(8'hA0, 8'h00, 8'h40, 8'h00); chk("R8 unloaded kept", r4, 8'hAA);
    xfer(8'hA0, 8'h00, 8'h41, 8'h00); chk("R8 slot1", r4, 8'h55);
    xfer(8'hA0, 8'h00, 8'h42, 8'h00); chk("R8 slot2 untouched", r4, 8'hFF);
    xfer(8'hA0, 8'h00, 8'h43, 8'h00); chk("R8 slot3", r4, 8'h66);
  endtask

  task automatic t_flash;
    xfer(8'h4D, 8'h00, 8'h00, 8'h00);
    xfer(8'h40, 8'h00, 8'h02, 8'h12);
    xfer(8'h48, 8'h00, 8'h02, 8'h34);
    xfer(8'h48, 8'h00, 8'h05, 8'h56);
    xfer(8'h4C, 8'h00, 8'h00, 8'h00);
    clks(660);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00);
    chk("R11 flash still busy past ee time", r4, 8'h01);
    clks(W_FL);
    xfer(8'h20, 8'h00, 8'h02, 8'h00); chk("R7 low loaded", r4, 8'h12);
    xfer(8'h28, 8'h00, 8'h02, 8'h00); chk("R7 high loaded", r4, 8'h34);
    xfer(8'h20, 8'h00, 8'h05, 8'h00); chk("R7 low not loaded", r4, 8'hFF);
    xfer(8'h28, 8'h00, 8'h05, 8'h00); chk("R10 high read", r4, 8'h56);
    xfer(8'h4D, 8'h00, 8'h01, 8'h00);
    xfer(8'h40, 8'h00, 8'h02, 8'h9A);
    xfer(8'h4C, 8'h00, 8'h00, 8'h00);
    clks(W_FL);
    xfer(8'h20, 8'h00, 8'h02, 8'h00); chk("R6 ext page 1", r4, 8'h9A);
    xfer(8'h4D, 8'h00, 8'h00, 8'h00);
    xfer(8'h20, 8'h00, 8'h02, 8'h00); chk("R6 ext page 0", r4, 8'h12);
  endtask

  task automatic t_ee_timing;
    xfer(8'hC0, 8'h00, 8'h60, 8'h01);
    clks(660);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00);
    chk("R11 ee done before flash time", r4, 8'h00);
  endtask

  task automatic t_cfg;
    xfer(8'h50, 8'h00, 8'h00, 8'h00); chk("R13 cfg reset", r4, 8'hE1);
    xfer(8'hAC, 8'hA0, 8'h00, 8'h3C);
    clks(W_CF);
    xfer(8'h50, 8'h00, 8'h00, 8'h00); chk("R13 cfg written", r4, 8'h3C);
  endtask

  task automatic t_erase;
    xfer(8'hAC, 8'h80, 8'h00, 8'h00);
    clks(1500);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00); chk("R11 erase busy", r4, 8'h01);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00); chk("R11 erase done", r4, 8'h00);
    xfer(8'hA0, 8'h00, 8'h10, 8'h00); chk("R4 ee erased", r4, 8'hFF);
    xfer(8'h28, 8'h00, 8'h05, 8'h00); chk("R4 flash erased", r4, 8'hFF);
    xfer(8'h50, 8'h00, 8'h00, 8'h00); chk("R4 cfg kept", r4, 8'h3C);
  endtask

  task automatic t_realign;
    xfer(8'hC0, 8'h00, 8'h41, 8'h77);
    clks(W_EE);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); mosi = 1'b1; clks(HALF); sck = 1'b1; clks(HALF); sck = 1'b0;
    end
    clks(IDLE + 20);
    xfer(8'hA0, 8'h00, 8'h41, 8'h00); chk("R2 idle realign", r4, 8'h77);
    isp_rst_n = 1'b1; clks(10); isp_rst_n = 1'b0; clks(4);
    xfer(8'hA0, 8'h00, 8'h41, 8'h00); chk("R3 relocked echo", r4, 8'h41);
    xfer(8'hAC, 8'h53, 8'h00, 8'h00);
    xfer(8'hA0, 8'h00, 8'h41, 8'h00); chk("R2 frame after reset", r4, 8'h77);
  endtask

  initial begin
    clks(5); rst_n = 1'b1; clks(5);
    t_locked;
    t_ee_byte;
    t_discard;
    t_ee_page;
    t_flash;
    t_ee_timing;
    clks(W_EE);
    t_cfg;
    t_erase;
    t_realign;
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule